// File: doc/BRIEF.md
# Dual-Context Pagemap Address Translator

This block turns a virtual address into a physical address by direct lookup in an on-chip pagemap that holds one entry for every virtual page. The upper bits of the address pick the entry and the lower bits are the offset within the page, which passes through unchanged. Each entry carries a resident flag, a dirty flag and a physical page number. If the entry is resident, the physical address is the physical page number placed above the offset. If it is not resident, the block raises a page fault and outputs no address. When a write access hits a resident page, that page's dirty flag is set.

Two complete pagemaps are held in hardware, one for the kernel and one for the user. Taking an interrupt makes the kernel map active. Returning from the interrupt makes the user map active again. A loading port lets the fault handler install or clear an entry in either map. On every fault, the block records the faulting page number, whether the access was a write, and which map was in use.

The default sizes are a scaled-down version of a 32-bit space with 8 KB pages and 1 MB of RAM: 8 page-number bits, 5 offset bits and 4 physical page bits. Every access request gets its response exactly one cycle later.

Top module: `dual_ctx_pagemap_mmu`

## Requirements
- R1: After reset, every entry in both maps is non-resident and its dirty flag is 0. The kernel map is active, `rsp_valid` is 0, and the fault record reads 0.
- R2: When `req_valid` is high in cycle t, `rsp_valid` is high in cycle t+1 and low otherwise. For a resident entry, `rsp_fault` is 0 and `rsp_paddr` is {ppn, offset}: the page number in bits [PA_W-1:OFF_W] and the request's low OFF_W bits below it.
- R3: An access to a non-resident entry gives `rsp_fault` = 1 and `rsp_paddr` = 0. `rsp_fault` is never high without `rsp_valid`.
- R4: A write access to a resident entry sets that entry's dirty flag at the end of the request cycle. A read access, or a write that faults, leaves the dirty flag unchanged.
- R5: A faulting access loads `flt_vpn`, `flt_write` and `flt_kernel` at the same edge that presents its response. Non-faulting cycles leave these three outputs unchanged.
- R6: A pulse on `irq_take` makes the kernel map active from the next cycle. A pulse on `irq_return` alone makes the user map active from the next cycle. If both pulse together, the kernel map wins. A request uses the map that is active in its own cycle, and `ctx_kernel` shows the active map.
- R7: A load through the write port changes only the entry named by `pw_kernel` and `pw_vpn`, and only at the next edge. A lookup of the same entry in the same cycle returns the entry's earlier contents.
- R8: If a port load and a dirtying write access target the same entry in the same cycle, the port's values win. The resulting dirty flag equals `pw_dirty`.
- R9: `rsp_dirty` reports the entry's dirty flag as it was stored when the request was made, before any update caused by that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_take | input | 1 | Interrupt entry pulse; makes the kernel map active |
| irq_return | input | 1 | Interrupt return pulse; makes the user map active |
| ctx_kernel | output | 1 | 1 while the kernel map is active |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_vaddr | input | VA_W | Virtual address: page number above the offset |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_fault | output | 1 | Page fault: the entry is not resident |
| rsp_dirty | output | 1 | Entry's dirty flag as stored before the access |
| rsp_paddr | output | PA_W | Physical address, 0 on a fault |
| pw_en | input | 1 | Load one pagemap entry |
| pw_kernel | input | 1 | Target map: 1 kernel, 0 user |
| pw_vpn | input | VPN_W | Target virtual page number |
| pw_resident | input | 1 | New resident flag |
| pw_dirty | input | 1 | New dirty flag |
| pw_ppn | input | PPN_W | New physical page number |
| flt_vpn | output | VPN_W | Page number of the last fault |
| flt_write | output | 1 | The last fault came from a write access |
| flt_kernel | output | 1 | The last fault occurred in the kernel map |

## Verification
Two pairs of events can fall on the same edge, and each pair is driven deliberately. In the first pair, a port load and a lookup of the same entry share a cycle. The response must carry the old mapping, and the load must be visible on the next lookup. In the second pair, a port load coincides with a write access that would set the dirty flag. A following read must show the port's dirty value. Random stimulus also overlaps port loads, accesses and interrupt pulses over a small set of page numbers, so these cases recur. Every response is compared against a reference pagemap kept in the bench.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int NUM_CTX = 2;
  localparam logic CTX_USER   = 1'b0;
  localparam logic CTX_KERNEL = 1'b1;
endpackage

// File: rtl/mmu_ctx_ctrl.sv
module mmu_ctx_ctrl
  import mmu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq_take,
  input  logic irq_return,
  output logic kernel_q
);
  // entry has priority over return
  always_ff @(posedge clk) begin
    if (rst)             kernel_q <= CTX_KERNEL;
    else if (irq_take)   kernel_q <= CTX_KERNEL;
    else if (irq_return) kernel_q <= CTX_USER;
  end
endmodule

// File: rtl/mmu_pagemap.sv
module mmu_pagemap #(
  parameter int VPN_W = 8,
  parameter int PPN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic             lk_write,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_res_now,
  output logic             lk_res_q,
  output logic             lk_dirty_q,
  output logic [PPN_W-1:0] lk_ppn_q,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_res,
  input  logic             wr_dirty,
  input  logic [PPN_W-1:0] wr_ppn
);
  localparam int DEPTH = 1 << VPN_W;

  // status flags live in flops so reset can clear them at once
  logic [DEPTH-1:0] res_vec;
  logic [DEPTH-1:0] dirty_vec;
  // page numbers live in a RAM with no reset
  logic [PPN_W-1:0] ppn_mem [DEPTH];

  assign lk_res_now = res_vec[lk_vpn];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vec   <= '0;
      dirty_vec <= '0;
    end else begin
      if (lk_en && lk_write && res_vec[lk_vpn])
        dirty_vec[lk_vpn] <= 1'b1;
      // port load is later in program order: it wins on collision
      if (wr_en) begin
        res_vec[wr_vpn]   <= wr_res;
        dirty_vec[wr_vpn] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_res_q   <= 1'b0;
      lk_dirty_q <= 1'b0;
    end else if (lk_en) begin
      lk_res_q   <= res_vec[lk_vpn];
      lk_dirty_q <= dirty_vec[lk_vpn];
    end
  end

  // read-before-write synchronous RAM
  always_ff @(posedge clk) begin
    if (wr_en) ppn_mem[wr_vpn] <= wr_ppn;
    if (lk_en) lk_ppn_q <= ppn_mem[lk_vpn];
  end
endmodule

// File: rtl/mmu_fault_log.sv
module mmu_fault_log #(
  parameter int VPN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_now,
  input  logic [VPN_W-1:0] vpn,
  input  logic             is_write,
  input  logic             is_kernel,
  output logic [VPN_W-1:0] flt_vpn,
  output logic             flt_write,
  output logic             flt_kernel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flt_vpn    <= '0;
      flt_write  <= 1'b0;
      flt_kernel <= 1'b0;
    end else if (fault_now) begin
      flt_vpn    <= vpn;
      flt_write  <= is_write;
      flt_kernel <= is_kernel;
    end
  end
endmodule

// File: rtl/dual_ctx_pagemap_mmu.sv
module dual_ctx_pagemap_mmu
  import mmu_pkg::*;
#(
  parameter int VPN_W = 8,
  parameter int OFF_W = 5,
  parameter int PPN_W = 4,
  localparam int VA_W = VPN_W + OFF_W,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_take,
  input  logic             irq_return,
  output logic             ctx_kernel,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic             rsp_dirty,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             pw_en,
  input  logic             pw_kernel,
  input  logic [VPN_W-1:0] pw_vpn,
  input  logic             pw_resident,
  input  logic             pw_dirty,
  input  logic [PPN_W-1:0] pw_ppn,
  output logic [VPN_W-1:0] flt_vpn,
  output logic             flt_write,
  output logic             flt_kernel
);
  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  mmu_ctx_ctrl u_ctx (
    .clk        (clk),
    .rst        (rst),
    .irq_take   (irq_take),
    .irq_return (irq_return),
    .kernel_q   (ctx_kernel)
  );

  logic [NUM_CTX-1:0] res_now;
  logic [NUM_CTX-1:0] res_q;
  logic [NUM_CTX-1:0] dirty_q;
  logic [PPN_W-1:0]   ppn_q [NUM_CTX];

  // index 1 is the kernel map, index 0 the user map
  for (genvar g = 0; g < NUM_CTX; g++) begin : g_map
    logic lk_en_g;
    logic wr_en_g;
    assign lk_en_g = req_valid && (ctx_kernel == 1'(g));
    assign wr_en_g = pw_en && (pw_kernel == 1'(g));

    mmu_pagemap #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_map (
      .clk        (clk),
      .rst        (rst),
      .lk_en      (lk_en_g),
      .lk_write   (req_write),
      .lk_vpn     (req_vpn),
      .lk_res_now (res_now[g]),
      .lk_res_q   (res_q[g]),
      .lk_dirty_q (dirty_q[g]),
      .lk_ppn_q   (ppn_q[g]),
      .wr_en      (wr_en_g),
      .wr_vpn     (pw_vpn),
      .wr_res     (pw_resident),
      .wr_dirty   (pw_dirty),
      .wr_ppn     (pw_ppn)
    );
  end

  logic fault_now;
  assign fault_now = req_valid && !res_now[ctx_kernel];

  mmu_fault_log #(.VPN_W(VPN_W)) u_flt (
    .clk        (clk),
    .rst        (rst),
    .fault_now  (fault_now),
    .vpn        (req_vpn),
    .is_write   (req_write),
    .is_kernel  (ctx_kernel),
    .flt_vpn    (flt_vpn),
    .flt_write  (flt_write),
    .flt_kernel (flt_kernel)
  );

  // response stage registers
  logic             v_q;
  logic             sel_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      sel_q <= 1'b0;
      off_q <= '0;
    end else begin
      v_q <= req_valid;
      if (req_valid) begin
        sel_q <= ctx_kernel;
        off_q <= req_off;
      end
    end
  end

  logic hit_q;
  assign hit_q     = v_q && res_q[sel_q];
  assign rsp_valid = v_q;
  assign rsp_fault = v_q && !res_q[sel_q];
  assign rsp_dirty = v_q && dirty_q[sel_q];
  assign rsp_paddr = hit_q ? {ppn_q[sel_q], off_q} : '0;
endmodule

// File: rtl/dual_ctx_pagemap_mmu_chk.sv
module dual_ctx_pagemap_mmu_chk #(
  parameter int VPN_W = 8,
  parameter int OFF_W = 5,
  parameter int PPN_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   irq_take,
  input logic                   irq_return,
  input logic                   ctx_kernel,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [VPN_W+OFF_W-1:0] req_vaddr,
  input logic                   rsp_valid,
  input logic                   rsp_fault,
  input logic [PPN_W+OFF_W-1:0] rsp_paddr,
  input logic [VPN_W-1:0]       flt_vpn,
  input logic                   flt_write
);
  p_fault_valid_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid);

  p_fault_no_addr_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_paddr == '0);

  p_rsp_timing_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rsp_valid == $past(req_valid));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_valid && !rsp_fault) |->
      rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  p_ctx_take_r6: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> ctx_kernel);

  p_ctx_return_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_return && !irq_take) |=> !ctx_kernel);

  p_fault_record_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_fault) |->
      (flt_vpn == $past(req_vaddr[VPN_W+OFF_W-1:OFF_W]) && flt_write == $past(req_write)));

  p_record_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !rsp_fault) |-> ($stable(flt_vpn) && $stable(flt_write)));
endmodule

bind dual_ctx_pagemap_mmu dual_ctx_pagemap_mmu_chk #(
  .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_take   (irq_take),
  .irq_return (irq_return),
  .ctx_kernel (ctx_kernel),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_vaddr  (req_vaddr),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .flt_vpn    (flt_vpn),
  .flt_write  (flt_write)
);

// File: tb/dual_ctx_pagemap_mmu_test.sv
module dual_ctx_pagemap_mmu_test;
  localparam int VPN_W = 8;
  localparam int OFF_W = 5;
  localparam int PPN_W = 4;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int DEPTH = 1 << VPN_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_take = 0, irq_return = 0, ctx_kernel;
  logic req_valid = 0, req_write = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic rsp_valid, rsp_fault, rsp_dirty;
  logic [PA_W-1:0] rsp_paddr;
  logic pw_en = 0, pw_kernel = 0, pw_resident = 0, pw_dirty = 0;
  logic [VPN_W-1:0] pw_vpn = '0;
  logic [PPN_W-1:0] pw_ppn = '0;
  logic [VPN_W-1:0] flt_vpn;
  logic flt_write, flt_kernel;

  always #10 clk = ~clk;

  dual_ctx_pagemap_mmu #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) uut (
    .clk(clk), .rst(rst), .irq_take(irq_take), .irq_return(irq_return),
    .ctx_kernel(ctx_kernel), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_dirty(rsp_dirty), .rsp_paddr(rsp_paddr), .pw_en(pw_en),
    .pw_kernel(pw_kernel), .pw_vpn(pw_vpn), .pw_resident(pw_resident),
    .pw_dirty(pw_dirty), .pw_ppn(pw_ppn), .flt_vpn(flt_vpn),
    .flt_write(flt_write), .flt_kernel(flt_kernel)
  );

  int checks = 0;
  int errors = 0;

  // reference pagemap
  bit             m_res   [2][DEPTH];
  bit             m_dirty [2][DEPTH];
  bit [PPN_W-1:0] m_ppn   [2][DEPTH];
  bit             m_ctx;
  bit [VPN_W-1:0] m_fvpn;
  bit             m_fwrite, m_fkernel;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [PA_W-1:0] exp_paddr(input bit res, input bit [PPN_W-1:0] ppn,
                                              input bit [OFF_W-1:0] off);
    return res ? {ppn, off} : '0;
  endfunction

  // one clock cycle with all inputs given; checks the response at the following edge
  task automatic step(input bit tk, input bit rt, input bit rv, input bit rw,
                      input bit [VA_W-1:0] va, input bit pe, input bit pk,
                      input bit [VPN_W-1:0] pv, input bit pr, input bit pd,
                      input bit [PPN_W-1:0] pp);
    bit ectx, eres, edirty;
    bit [VPN_W-1:0] evpn;
    bit [PPN_W-1:0] eppn;
    irq_take = tk; irq_return = rt; req_valid = rv; req_write = rw; req_vaddr = va;
    pw_en = pe; pw_kernel = pk; pw_vpn = pv; pw_resident = pr; pw_dirty = pd; pw_ppn = pp;
    ectx = m_ctx; evpn = va[VA_W-1:OFF_W];
    eres = m_res[ectx][evpn]; edirty = m_dirty[ectx][evpn]; eppn = m_ppn[ectx][evpn];
    @(posedge clk);
    if (rv && !eres) begin m_fvpn = evpn; m_fwrite = rw; m_fkernel = ectx; end
    if (rv && rw && eres) m_dirty[ectx][evpn] = 1'b1;
    if (pe) begin m_res[pk][pv] = pr; m_dirty[pk][pv] = pd; m_ppn[pk][pv] = pp; end
    if (tk) m_ctx = 1'b1; else if (rt) m_ctx = 1'b0;
    #2;
    chk(rsp_valid == rv, "R2 valid", rsp_valid, rv);
    if (rv) begin
      chk(rsp_fault == !eres, "R3 fault", rsp_fault, !eres);
      chk(rsp_paddr == exp_paddr(eres, eppn, va[OFF_W-1:0]), "R2 paddr",
          rsp_paddr, exp_paddr(eres, eppn, va[OFF_W-1:0]));
      chk(rsp_dirty == edirty, "R9 dirty", rsp_dirty, edirty);
    end
    chk(ctx_kernel == m_ctx, "R6 ctx", ctx_kernel, m_ctx);
    chk(flt_vpn == m_fvpn && flt_write == m_fwrite && flt_kernel == m_fkernel,
        "R5 record", {flt_vpn, flt_write, flt_kernel}, {m_fvpn, m_fwrite, m_fkernel});
  endtask

  task automatic idle();
    step(0, 0, 0, 0, '0, 0, 0, '0, 0, 0, '0);
  endtask

  task automatic access(input bit rw, input bit [VPN_W-1:0] vpn, input bit [OFF_W-1:0] off);
    step(0, 0, 1, rw, {vpn, off}, 0, 0, '0, 0, 0, '0);
  endtask

  task automatic load(input bit pk, input bit [VPN_W-1:0] pv, input bit pr, input bit pd,
                      input bit [PPN_W-1:0] pp);
    step(0, 0, 0, 0, '0, 1, pk, pv, pr, pd, pp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    m_ctx = 1'b1; m_fvpn = '0; m_fwrite = 0; m_fkernel = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk(ctx_kernel == 1'b1, "R1 kernel after reset", ctx_kernel, 1);
    chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
    chk(flt_vpn == '0 && !flt_write && !flt_kernel, "R1 record clear",
        {flt_vpn, flt_write, flt_kernel}, 0);
    rst = 1'b0;

    // R1: every entry faults in both maps
    access(0, 8'd3, 5'd1);
    chk(rsp_fault == 1'b1, "R1 kernel entry not resident", rsp_fault, 1);
    step(0, 1, 0, 0, '0, 0, 0, '0, 0, 0, '0);
    access(1, 8'd255, 5'd31);
    chk(rsp_fault == 1'b1, "R1 user entry not resident", rsp_fault, 1);
    chk(flt_write == 1'b1 && flt_kernel == 1'b0, "R5 write fault in user",
        {flt_write, flt_kernel}, 2'b10);

    // R2: resident translation
    load(0, 8'd5, 1, 0, 4'd9);
    access(0, 8'd5, 5'd17);
    chk(rsp_paddr == {4'd9, 5'd17}, "R2 translate", rsp_paddr, {4'd9, 5'd17});

    // R4: write hit sets dirty, read does not
    access(0, 8'd5, 5'd0);
    chk(rsp_dirty == 1'b0, "R4 read leaves dirty", rsp_dirty, 0);
    access(1, 8'd5, 5'd2);
    chk(rsp_dirty == 1'b0, "R9 dirty before own write", rsp_dirty, 0);
    access(0, 8'd5, 5'd3);
    chk(rsp_dirty == 1'b1, "R4 write hit dirtied", rsp_dirty, 1);

    // R4: faulting write leaves dirty clear
    access(1, 8'd6, 5'd4);
    chk(flt_vpn == 8'd6, "R5 fault page", flt_vpn, 6);
    load(0, 8'd6, 1, 0, 4'd3);
    access(0, 8'd6, 5'd4);
    chk(rsp_dirty == 1'b0, "R4 faulting write no dirty", rsp_dirty, 0);

    // R7: same-cycle load and lookup return old mapping
    step(0, 0, 1, 0, {8'd5, 5'd8}, 1, 0, 8'd5, 1, 1, 4'd2);
    chk(rsp_paddr == {4'd9, 5'd8}, "R7 old mapping same cycle", rsp_paddr, {4'd9, 5'd8});
    load(1, 8'd5, 1, 0, 4'd7);
    access(0, 8'd5, 5'd8);
    chk(rsp_paddr == {4'd2, 5'd8}, "R7 new mapping, kernel load isolated",
        rsp_paddr, {4'd2, 5'd8});

    // R8: port load beats dirty set
    step(0, 0, 1, 1, {8'd6, 5'd0}, 1, 0, 8'd6, 1, 0, 4'd3);
    access(0, 8'd6, 5'd0);
    chk(rsp_dirty == 1'b0, "R8 port dirty wins", rsp_dirty, 0);

    // R6: both pulses -> kernel; request in same cycle uses old map
    step(1, 1, 1, 0, {8'd5, 5'd1}, 0, 0, '0, 0, 0, '0);
    chk(ctx_kernel == 1'b1 && rsp_fault == 1'b0, "R6 take wins, old map used",
        {ctx_kernel, rsp_fault}, 2'b10);
    access(0, 8'd5, 5'd1);
    chk(rsp_paddr == {4'd7, 5'd1}, "R6 kernel map now active", rsp_paddr, {4'd7, 5'd1});
    step(0, 1, 1, 0, {8'd5, 5'd1}, 0, 0, '0, 0, 0, '0);
    chk(rsp_paddr == {4'd7, 5'd1}, "R6 return uses kernel this cycle", rsp_paddr, {4'd7, 5'd1});
    idle();
    chk(ctx_kernel == 1'b0, "R6 user after return", ctx_kernel, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit tk, rt, rv, rw, pe, pk, pr, pd;
      bit [VPN_W-1:0] vpn, pv;
      bit [PPN_W-1:0] pp;
      bit [OFF_W-1:0] off;
      tk = ($urandom_range(0, 19) == 0);
      rt = ($urandom_range(0, 19) == 0);
      rv = ($urandom_range(0, 3) != 0);
      rw = $urandom_range(0, 1);
      vpn = ($urandom_range(0, 15) == 0) ? 8'd255 : 8'($urandom_range(0, 7));
      off = 5'($urandom);
      pe = ($urandom_range(0, 3) == 0);
      pk = $urandom_range(0, 1);
      pv = ($urandom_range(0, 15) == 0) ? 8'd255 : 8'($urandom_range(0, 7));
      pr = ($urandom_range(0, 3) != 0);
      pd = ($urandom_range(0, 3) == 0);
      pp = 4'($urandom);
      step(tk, rt, rv, rw, {vpn, off}, pe, pk, pv, pr, pd, pp);
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule